// File: doc/BRIEF.md
# Serial Configuration Slave for a Clock Generator

This block is the configuration port of a clock generator. It sits on a two-wire serial bus (SCL clock, SDA open-drain data), answers to the 7-bit device address 69h, and keeps six 8-bit control bytes. The bytes drive the rest of the chip in parallel through a flat output bus, with byte 0 in the least significant eight bits.

A write transfer is a block write. After the address, the controller sends two framing bytes: a command byte and then a length byte. The slave acknowledges both and keeps neither. Every byte after them is stored in order, starting at register 0. A read transfer is a block read. The slave first returns a length byte and then registers 0, 1, 2 and onward. There is no register offset, so a reader always starts at byte 0 and a writer can only change byte k by also rewriting bytes 0 to k-1.

SCL and SDA are resynchronised to the system clock, which must run at least ten times the 100 kbit/s bit rate. START and STOP are recognised as SDA edges while SCL is high. The slave pulls SDA low only while SCL is low.

Top module: `clkgen_cfg_slave`

## Requirements
- R1: Only the address byte D2h (write) or D3h (read) is acknowledged. For any other address byte the slave leaves SDA released during the ninth clock, ignores the bus until the next STOP, and keeps every register unchanged.
- R2: During a matched write, the slave pulls SDA low for the whole ninth SCL clock of the address byte and of every following byte.
- R3: In a write, the first two bytes after the address change nothing. The k-th byte after them (k counted from 0) is stored in register k. A write with no data bytes leaves all registers unchanged.
- R4: When STOP arrives after a complete byte, the bytes already received stay stored. A byte cut off by STOP before its eighth bit is dropped, and the register it was aimed at keeps its old value.
- R5: Data bytes beyond register 5 are acknowledged and have no effect on any register.
- R6: A read first returns 06h and then registers 0 to 5, most significant bit first. Any byte requested after register 5 reads FFh. When the controller does not acknowledge a byte, the slave releases SDA and stops sending.
- R7: After reset, register 0 holds 00h and registers 1 to 5 hold FFh. The slave is idle and leaves SDA released.
- R8: A START that arrives in the middle of a transfer ends that transfer without changing any register. The slave then ignores the bus, including any address that follows, until the next STOP.
- R9: The slave changes its SDA pull only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 10x the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_pull_o | output | 1 | High pulls SDA low (open-drain enable) |
| cfg_bytes_o | output | 48 | Register bytes, byte k at bits 8k+7:8k |

## Verification
Some properties are checked on every cycle. Register contents change only on a write strobe whose index is inside the bank, the SDA pull only changes while the synchronised SCL is low, STOP always leaves SDA released, and reset restores the default bytes. The remaining behaviour only shows up in whole bus transfers, so the bench has to drive it. That covers discarding the two framing bytes, the order in which data bytes land, a read that starts with the length byte, FFh padding past the last register, dropping of a cut-off byte, and a repeated START or foreign address that silences the slave until STOP.

// File: rtl/clkgen_cfg_pkg.sv
package clkgen_cfg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK
  } cfg_state_t;

  localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/clkgen_cfg_sync.sv
module clkgen_cfg_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_q;
  logic              sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  // data edges are only meaningful while the clock stayed high
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/clkgen_cfg_regbank.sv
module clkgen_cfg_regbank #(
  parameter int unsigned NUM_BYTES = 6,
  parameter logic [7:0]  RST_FIRST = 8'h00,
  parameter logic [7:0]  RST_OTHER = 8'hFF,
  localparam int unsigned IDX_W    = $clog2(NUM_BYTES)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   we,
  input  logic [IDX_W-1:0]       widx,
  input  logic [7:0]             wdata,
  output logic [NUM_BYTES*8-1:0] bytes_o
);

  for (genvar k = 0; k < NUM_BYTES; k++) begin : g_byte
    localparam logic [7:0] RST_VAL = (k == 0) ? RST_FIRST : RST_OTHER;
    logic [7:0] q;

    always_ff @(posedge clk) begin
      if (rst) begin
        q <= RST_VAL;
      end else if (we && (widx == IDX_W'(k))) begin
        q <= wdata;
      end
    end

    assign bytes_o[k*8 +: 8] = q;
  end

endmodule

// File: rtl/clkgen_cfg_ctrl.sv
module clkgen_cfg_ctrl
  import clkgen_cfg_pkg::*;
#(
  parameter int unsigned NUM_BYTES = 6,
  parameter logic [6:0]  DEV_ADDR  = 7'h69,
  localparam int unsigned IDX_W    = $clog2(NUM_BYTES),
  localparam int unsigned CNT_W    = $clog2(NUM_BYTES + 4)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   sda_s,
  input  logic                   scl_rise,
  input  logic                   scl_fall,
  input  logic                   start_det,
  input  logic                   stop_det,
  input  logic [NUM_BYTES*8-1:0] rd_bytes,
  output logic                   reg_we,
  output logic [IDX_W-1:0]       reg_idx,
  output logic [7:0]             reg_wdata,
  output logic                   sda_pull_o
);

  localparam logic [CNT_W-1:0] CNT_MAX   = CNT_W'(NUM_BYTES + 3);
  localparam logic [CNT_W-1:0] DATA_BASE = CNT_W'(2);
  localparam logic [CNT_W-1:0] DATA_END  = CNT_W'(NUM_BYTES + 2);
  localparam logic [7:0]       LEN_BYTE  = 8'(NUM_BYTES);

  cfg_state_t       state;
  logic [2:0]       bit_cnt;
  logic [7:0]       shreg;
  logic             is_addr;
  logic             rd_mode;
  logic             done;
  logic [CNT_W-1:0] byte_cnt;

  logic [7:0]       rx_byte;
  logic             wr_hit;
  logic [CNT_W-1:0] nxt_cnt;
  logic [7:0]       nxt_tx;

  assign rx_byte = {shreg[6:0], sda_s};
  assign wr_hit  = (byte_cnt >= DATA_BASE) && (byte_cnt < DATA_END);
  assign nxt_cnt = (byte_cnt == CNT_MAX) ? byte_cnt : byte_cnt + CNT_W'(1);

  // readback byte for the next slot: slot 0 is the length, slot k+1 is register k
  always_comb begin
    nxt_tx = 8'hFF;
    for (int k = 0; k < NUM_BYTES; k++) begin
      if (nxt_cnt == CNT_W'(k + 1)) nxt_tx = rd_bytes[k*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      bit_cnt    <= '0;
      shreg      <= '0;
      is_addr    <= 1'b0;
      rd_mode    <= 1'b0;
      done       <= 1'b0;
      byte_cnt   <= '0;
      sda_pull_o <= 1'b0;
      reg_we     <= 1'b0;
      reg_idx    <= '0;
      reg_wdata  <= '0;
    end else begin
      reg_we <= 1'b0;
      if (stop_det) begin
        state      <= ST_IDLE;
        sda_pull_o <= 1'b0;
        done       <= 1'b0;
      end else if (start_det) begin
        sda_pull_o <= 1'b0;
        done       <= 1'b0;
        bit_cnt    <= '0;
        if (state == ST_IDLE) begin
          state    <= ST_RX;
          is_addr  <= 1'b1;
          rd_mode  <= 1'b0;
          byte_cnt <= '0;
        end else begin
          state <= ST_WAIT;
        end
      end else begin
        unique case (state)
          ST_RX: begin
            if (scl_rise && !done) begin
              shreg   <= rx_byte;
              bit_cnt <= bit_cnt + 3'd1;
              if (bit_cnt == 3'd7) begin
                if (is_addr) begin
                  if (rx_byte[7:1] == DEV_ADDR) begin
                    done    <= 1'b1;
                    rd_mode <= rx_byte[0];
                  end else begin
                    state <= ST_WAIT;
                  end
                end else begin
                  done <= 1'b1;
                  if (wr_hit) begin
                    reg_we    <= 1'b1;
                    reg_idx   <= IDX_W'(byte_cnt - DATA_BASE);
                    reg_wdata <= rx_byte;
                  end
                  byte_cnt <= nxt_cnt;
                end
              end
            end else if (scl_fall && done) begin
              done       <= 1'b0;
              sda_pull_o <= 1'b1;
              state      <= ST_RX_ACK;
            end
          end
          ST_RX_ACK: begin
            if (scl_fall) begin
              bit_cnt <= '0;
              is_addr <= 1'b0;
              if (is_addr && rd_mode) begin
                state      <= ST_TX;
                byte_cnt   <= '0;
                shreg      <= LEN_BYTE;
                sda_pull_o <= ~LEN_BYTE[7];
              end else begin
                state      <= ST_RX;
                sda_pull_o <= 1'b0;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bit_cnt == 3'd7) begin
                bit_cnt    <= '0;
                sda_pull_o <= 1'b0;
                state      <= ST_TX_ACK;
              end else begin
                bit_cnt    <= bit_cnt + 3'd1;
                shreg      <= {shreg[6:0], 1'b0};
                sda_pull_o <= ~shreg[6];
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) begin
              if (sda_s) state <= ST_WAIT;
              else       done  <= 1'b1;
            end else if (scl_fall && done) begin
              done       <= 1'b0;
              byte_cnt   <= nxt_cnt;
              shreg      <= nxt_tx;
              sda_pull_o <= ~nxt_tx[7];
              state      <= ST_TX;
            end
          end
          default: begin
            sda_pull_o <= 1'b0;
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/clkgen_cfg_slave.sv
module clkgen_cfg_slave #(
  parameter int unsigned NUM_BYTES   = 6,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [6:0]  DEV_ADDR    = 7'h69,
  parameter logic [7:0]  RST_FIRST   = 8'h00,
  parameter logic [7:0]  RST_OTHER   = 8'hFF
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   scl_i,
  input  logic                   sda_i,
  output logic                   sda_pull_o,
  output logic [NUM_BYTES*8-1:0] cfg_bytes_o
);

  localparam int unsigned IDX_W = $clog2(NUM_BYTES);

  logic             scl_s;
  logic             sda_s;
  logic             scl_rise;
  logic             scl_fall;
  logic             start_det;
  logic             stop_det;
  logic             reg_we;
  logic [IDX_W-1:0] reg_idx;
  logic [7:0]       reg_wdata;

  clkgen_cfg_sync #(
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk      (clk),
    .rst      (rst),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  clkgen_cfg_ctrl #(
    .NUM_BYTES(NUM_BYTES),
    .DEV_ADDR (DEV_ADDR)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .rd_bytes  (cfg_bytes_o),
    .reg_we    (reg_we),
    .reg_idx   (reg_idx),
    .reg_wdata (reg_wdata),
    .sda_pull_o(sda_pull_o)
  );

  clkgen_cfg_regbank #(
    .NUM_BYTES(NUM_BYTES),
    .RST_FIRST(RST_FIRST),
    .RST_OTHER(RST_OTHER)
  ) u_regs (
    .clk    (clk),
    .rst    (rst),
    .we     (reg_we),
    .widx   (reg_idx),
    .wdata  (reg_wdata),
    .bytes_o(cfg_bytes_o)
  );

endmodule

// File: rtl/clkgen_cfg_checker.sv
module clkgen_cfg_checker #(
  parameter int unsigned NUM_BYTES = 6,
  parameter logic [7:0]  RST_FIRST = 8'h00,
  parameter logic [7:0]  RST_OTHER = 8'hFF,
  localparam int unsigned IDX_W    = $clog2(NUM_BYTES)
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   scl_s,
  input logic                   stop_det,
  input logic                   reg_we,
  input logic [IDX_W-1:0]       reg_idx,
  input logic                   sda_pull_o,
  input logic [NUM_BYTES*8-1:0] cfg_bytes_o
);

  localparam logic [NUM_BYTES*8-1:0] DEFAULTS = {{(NUM_BYTES-1){RST_OTHER}}, RST_FIRST};

  // R7: reset brings back the default bytes and a released SDA
  p_defaults_r7: assert property (@(posedge clk)
    rst |=> (cfg_bytes_o == DEFAULTS) && !sda_pull_o);

  // R3: register contents move only in the cycle after a write strobe
  p_hold_regs_r3: assert property (@(posedge clk) disable iff (rst)
    !reg_we |=> $stable(cfg_bytes_o));

  // R5: a write strobe never targets a slot outside the bank
  p_idx_range_r5: assert property (@(posedge clk) disable iff (rst)
    reg_we |-> (reg_idx < IDX_W'(NUM_BYTES)));

  // R9: the pull is switched on only while SCL is low
  p_pull_on_low_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_pull_o) |-> !scl_s);

  // R9: the pull is switched off only while SCL is low
  p_pull_off_low_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(sda_pull_o) |-> !scl_s);

  // R4: after STOP the slave holds SDA released
  p_stop_release_r4: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_pull_o);

endmodule

bind clkgen_cfg_slave clkgen_cfg_checker #(
  .NUM_BYTES(NUM_BYTES),
  .RST_FIRST(RST_FIRST),
  .RST_OTHER(RST_OTHER)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .scl_s      (scl_s),
  .stop_det   (stop_det),
  .reg_we     (reg_we),
  .reg_idx    (reg_idx),
  .sda_pull_o (sda_pull_o),
  .cfg_bytes_o(cfg_bytes_o)
);

// File: tb/test_clkgen_cfg_slave.sv
module test_clkgen_cfg_slave;

  localparam int NB  = 6;
  localparam int QTR = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          m_scl = 1'b1;
  logic          m_sda_low = 1'b0;
  logic          slv_low;
  logic          sda_line;
  logic [NB*8-1:0] cfg;

  int n_chk = 0;
  int n_fail = 0;
  int r9_viol = 0;
  bit finished = 0;

  logic [7:0] model [NB];
  logic [7:0] wbuf  [16];

  always #5 clk = ~clk;

  assign sda_line = ~(m_sda_low | slv_low);

  clkgen_cfg_slave i_clkgen_cfg_slave (
    .clk        (clk),
    .rst        (rst),
    .scl_i      (m_scl),
    .sda_i      (sda_line),
    .sda_pull_o (slv_low),
    .cfg_bytes_o(cfg)
  );

  // R9 monitor: slave pull must not move while SCL is held high
  logic prev_low = 1'b0;
  logic prev_scl = 1'b1;
  always @(negedge clk) begin
    if (!rst && m_scl && prev_scl && (slv_low != prev_low)) r9_viol++;
    prev_low <= slv_low;
    prev_scl <= m_scl;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hq(input int n);
    repeat (n * QTR) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda_low = 1'b0; hq(1);
    m_scl = 1'b1;     hq(1);
    m_sda_low = 1'b1; hq(1);
    m_scl = 1'b0;     hq(1);
  endtask

  task automatic bus_stop();
    m_sda_low = 1'b1; hq(1);
    m_scl = 1'b1;     hq(1);
    m_sda_low = 1'b0; hq(2);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      m_sda_low = ~b[7-i]; hq(1);
      m_scl = 1'b1;        hq(2);
      m_scl = 1'b0;        hq(1);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    send_bits(b, 8);
    m_sda_low = 1'b0; hq(1);
    m_scl = 1'b1;     hq(1);
    acked = ~sda_line; hq(1);
    m_scl = 1'b0;     hq(1);
  endtask

  task automatic recv_byte(input logic ack_it, output logic [7:0] b);
    m_sda_low = 1'b0;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      hq(1); m_scl = 1'b1;
      hq(1); b = {b[6:0], sda_line};
      hq(1); m_scl = 1'b0;
    end
    m_sda_low = ack_it; hq(1);
    m_scl = 1'b1;       hq(2);
    m_scl = 1'b0;       hq(1);
    m_sda_low = 1'b0;
  endtask

  function automatic logic [7:0] exp_read(input int k);
    return (k < NB) ? model[k] : 8'hFF;
  endfunction

  task automatic check_bank(input string req);
    for (int k = 0; k < NB; k++) chk(req, cfg[k*8 +: 8], model[k]);
  endtask

  // block write of n data bytes from wbuf
  task automatic do_write(input int n);
    logic a;
    bus_start();
    send_byte(8'hD2, a);                      chk("R1 write address ack", a, 1);
    send_byte(8'($urandom_range(0, 255)), a); chk("R2 command byte ack", a, 1);
    send_byte(8'($urandom_range(0, 255)), a); chk("R2 length byte ack", a, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], a);
      chk((i < NB) ? "R2 data ack" : "R5 overflow ack", a, 1);
      if (i < NB) model[i] = wbuf[i];
    end
    bus_stop();
    hq(1);
    check_bank((n > NB) ? "R5 bank after long write" : "R3 bank after write");
  endtask

  // block read of n register slots after the length byte
  task automatic do_read(input int n);
    logic a;
    logic [7:0] b;
    bus_start();
    send_byte(8'hD3, a); chk("R1 read address ack", a, 1);
    recv_byte(1'b1, b);  chk("R6 length byte", b, 8'h06);
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, b);
      chk((i < NB) ? "R6 readback" : "R6 padding FFh", b, exp_read(i));
    end
    hq(1);
    chk("R6 released after nack", slv_low, 0);
    bus_stop();
  endtask

  initial begin
    logic a;
    void'($urandom(32'h00C0FFEE));
    for (int k = 0; k < NB; k++) model[k] = (k == 0) ? 8'h00 : 8'hFF;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);

    // R7 reset state
    check_bank("R7 reset bank");
    chk("R7 SDA released", slv_low, 0);
    do_read(8);

    // R1 foreign write address
    bus_start();
    send_byte(8'hD4, a); chk("R1 foreign address nack", a, 0);
    send_byte(8'h00, a); chk("R1 ignored byte nack", a, 0);
    send_byte(8'h11, a);
    bus_stop(); hq(1);
    check_bank("R1 bank unchanged");

    // R1 foreign read address
    bus_start();
    send_byte(8'hA3, a); chk("R1 foreign read nack", a, 0);
    bus_stop();

    // R3 write with only framing bytes
    do_write(0);

    // R3 directed full write
    for (int i = 0; i < NB; i++) wbuf[i] = 8'h5A + 8'(i * 17);
    do_write(NB);
    do_read(NB);

    // R4 stop inside a byte
    bus_start();
    send_byte(8'hD2, a); send_byte(8'h00, a); send_byte(8'h02, a);
    send_byte(8'hC3, a); chk("R4 complete byte ack", a, 1);
    model[0] = 8'hC3;
    send_bits(8'h3C, 4);
    bus_stop(); hq(1);
    check_bank("R4 partial byte dropped");

    // R8 repeated start mid-transfer, following address ignored
    bus_start();
    send_byte(8'hD2, a); send_byte(8'h00, a); send_byte(8'h02, a);
    send_bits(8'h99, 5);
    bus_start();
    send_byte(8'hD2, a); chk("R8 address after restart ignored", a, 0);
    send_byte(8'h77, a);
    bus_stop(); hq(1);
    check_bank("R8 bank unchanged");

    // R5 long write
    for (int i = 0; i < 10; i++) wbuf[i] = 8'($urandom_range(0, 255));
    do_write(10);
    do_read(9);

    // random mix
    for (int it = 0; it < 12; it++) begin
      int n;
      n = $urandom_range(0, 9);
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom_range(0, 255));
      do_write(n);
      do_read($urandom_range(1, 9));
    end

    chk("R9 pull steady while SCL high", r9_viol, 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule